// File: doc/BRIEF.md
# Ratio-Clocked Peripheral Register Access Bridge

This block sits between a CPU request port and a 16-bit peripheral register port. It reproduces the access timing of a chip in which the CPU, the internal bus and the peripheral bus run on three clocks whose frequencies are integer multiples of each other. The whole block runs on the fastest clock, the CPU clock. The two slower clocks are represented as clock-enable strobes, `bus_ce` and `prf_ce`. Each strobe is high in the CPU cycles that begin a cycle of its own domain.

One read or write is accepted at a time. The access is not a fixed wait count. It starts with a fixed preparation phase. Next comes a wait for the internal-bus edge, one internal-bus cycle, and a wait for the peripheral edge. Then the peripheral register is held for two peripheral cycles. A read spends two more CPU cycles bringing the data back. The two waits depend on where the request lands relative to the strobes. The requester sees a one-cycle `done` pulse. For a read, the returned data is valid in that same cycle.

Cycle numbering used below: a request is accepted at the clock edge that samples `req_valid` high while `busy` is low. Cycle 0 is the first CPU cycle after that edge. B and P are the applied CPU:bus and bus:peripheral ratios.

Top module: `periph_access_bridge`

## Requirements
- R1: After reset, `busy`, `done` and `prf_sel` are low and `rd_data` is zero, and both `bus_ce` and `prf_ce` are high in the first cycle after reset is released.
- R2: The bus ratio code maps 0,1,2,3,4 to B = 1,2,3,4,8, and the codes 5, 6 and 7 give B = 1. The peripheral ratio code maps 0,1,2,3 to P = 1,2,3,4, and the codes 4 to 7 give P = 1.
- R3: `bus_ce` is high once every B cycles. `prf_ce` is high once every B·P cycles and only in cycles where `bus_ce` is high. When a ratio differing from the current one is applied, both strobes are high in the very next cycle.
- R4: Ratio codes are applied only on edges where the block is idle. Changing the codes during an access has no effect on that access.
- R5: A write takes this many cycles: 3 preparation cycles, then n cycles until the first `bus_ce` at or after cycle 3, then B cycles of bus stage, then m·B cycles until the first `prf_ce` at or after the end of the bus stage, then 2·B·P cycles of peripheral stage. Call the total L. `done` is high in cycle L.
- R6: A read has the same stages and then two more cycles, so `done` is high in cycle L+2.
- R7: A request presented while `busy` is high is ignored. It produces no second `done`, it does not extend `busy`, and it does not alter any peripheral register.
- R8: `done` is high for exactly one cycle per access. `busy` is high from cycle 0 up to the cycle before `done` and is low in the `done` cycle.
- R9: `prf_sel` is high for exactly the 2·B·P cycles of the peripheral stage. Throughout those cycles, `prf_addr` equals `req_addr` without its bit 0, and `prf_write` equals the request's write flag.
- R10: With `req_size`=1 (half-word), both lanes are enabled, `prf_lane_en`=2'b11, and `req_wdata` is passed unchanged. With `req_size`=0 (byte), `req_addr[0]` picks the lane: 0 is bits 7:0 and 1 is bits 15:8. Only that lane is enabled, and it carries `req_wdata[7:0]`.
- R11: In the read `done` cycle, `rd_data` holds the peripheral word for a half-word read. For a byte read it holds the lane selected by `req_addr[0]`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus_ratio | input | 3 | CPU:bus ratio code |
| cfg_prf_ratio | input | 3 | Bus:peripheral ratio code |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 1 = half-word, 0 = byte |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| bus_ce | output | 1 | Internal-bus clock enable |
| prf_ce | output | 1 | Peripheral clock enable |
| prf_sel | output | 1 | Peripheral stage active |
| prf_write | output | 1 | Peripheral write |
| prf_addr | output | 11 | Peripheral half-word address |
| prf_wdata | output | 16 | Peripheral write data |
| prf_lane_en | output | 2 | Byte lane enables |
| prf_rdata | input | 16 | Peripheral read data |

## Verification
The bench covers every supported ratio pair plus unsupported codes. For each one it starts requests at several strobe phases and computes n and m from the strobe history it sees. A design that counted a fixed number of waits, or that started the bus stage one cycle off its edge, would miss `done` by a few cycles only at some phases. A design that put no extra cycles on the read return path would finish reads two cycles early. The bench injects a request and a ratio change in mid-access. A design that accepted either would show a second `done`, a stretched `busy` or a corrupted register. Byte accesses on both lanes catch a swapped lane select or a read result that is not zero-extended.

// File: rtl/pab_pkg.sv
// Shared constants, state type and ratio decoders for the peripheral access bridge.
// Assumes the supported ratio sets are fixed: bus 1,2,3,4,8 and peripheral 1..4.
package pab_pkg;

    localparam int unsigned CODE_W        = 3;
    localparam int unsigned BUS_RATIO_MAX = 8;
    localparam int unsigned PRF_RATIO_MAX = 4;
    localparam int unsigned BR_W          = $clog2(BUS_RATIO_MAX + 1);
    localparam int unsigned PR_W          = $clog2(PRF_RATIO_MAX + 1);
    localparam int unsigned PREP_CYCLES   = 3;
    localparam int unsigned RET_CYCLES    = 2;
    localparam int unsigned PRF_STAGE_LEN = 2;
    localparam int unsigned WAIT_W        = $clog2(PRF_STAGE_LEN * BUS_RATIO_MAX * PRF_RATIO_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_BUSW,
        ST_BUSS,
        ST_PRFW,
        ST_PRFS,
        ST_RET
    } seq_state_t;

    // Map a CPU:bus ratio code to the ratio; unsupported codes give 1.
    function automatic logic [BR_W-1:0] decode_bus_ratio(input logic [CODE_W-1:0] code);
        logic [BR_W-1:0] r;
        case (code)
            3'd1:    r = BR_W'(2);
            3'd2:    r = BR_W'(3);
            3'd3:    r = BR_W'(4);
            3'd4:    r = BR_W'(8);
            default: r = BR_W'(1);
        endcase
        return r;
    endfunction

    // Map a bus:peripheral ratio code to the ratio; unsupported codes give 1.
    function automatic logic [PR_W-1:0] decode_prf_ratio(input logic [CODE_W-1:0] code);
        logic [PR_W-1:0] r;
        case (code)
            3'd1:    r = PR_W'(2);
            3'd2:    r = PR_W'(3);
            3'd3:    r = PR_W'(4);
            default: r = PR_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pab_ratio_cfg.sv
// Ratio configuration holder. Decodes the ratio codes and applies them only
// while the sequencer is idle. Raises restart in the cycle a differing value
// is applied so the strobe counters realign to phase zero.
module pab_ratio_cfg
    import pab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic [CODE_W-1:0] bus_code,
    input  logic [CODE_W-1:0] prf_code,
    output logic [BR_W-1:0]   bus_ratio,
    output logic [PR_W-1:0]   prf_ratio,
    output logic              restart
);

    logic [BR_W-1:0] bus_next;
    logic [PR_W-1:0] prf_next;

    // Decode the requested ratios.
    always_comb begin
        bus_next = decode_bus_ratio(bus_code);
        prf_next = decode_prf_ratio(prf_code);
    end

    assign restart = idle && ((bus_next != bus_ratio) || (prf_next != prf_ratio));

    // Hold the applied ratios; reload only on an idle edge with a new value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ratio <= BR_W'(1);
            prf_ratio <= PR_W'(1);
        end else if (restart) begin
            bus_ratio <= bus_next;
            prf_ratio <= prf_next;
        end
    end

endmodule

// File: rtl/pab_strobe_gen.sv
// Clock-enable strobe generator. Models the internal-bus and peripheral
// clocks as enables on the CPU clock, from free-running counters reloaded
// from the applied ratios. Assumes ratios are at least 1.
module pab_strobe_gen
    import pab_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [BR_W-1:0] bus_ratio,
    input  logic [PR_W-1:0] prf_ratio,
    output logic            bus_ce,
    output logic            prf_ce
);

    logic [BR_W-1:0] bus_cnt;
    logic [PR_W-1:0] prf_cnt;

    assign bus_ce = (bus_cnt == '0);
    assign prf_ce = bus_ce && (prf_cnt == '0);

    // Count CPU cycles within one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            bus_cnt <= '0;
        end else if (bus_cnt == bus_ratio - 1'b1) begin
            bus_cnt <= '0;
        end else begin
            bus_cnt <= bus_cnt + 1'b1;
        end
    end

    // Count bus cycles within one peripheral cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            prf_cnt <= '0;
        end else if (bus_ce) begin
            if (prf_cnt == prf_ratio - 1'b1) begin
                prf_cnt <= '0;
            end else begin
                prf_cnt <= prf_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pab_lane.sv
// Byte-lane steering between a full-width request and the peripheral path.
// Full-size accesses pass straight through; byte accesses pick the lane
// from the low address bits and zero-extend read data. Assumes DATA_W is a
// multiple of 8.
module pab_lane #(
    parameter int unsigned DATA_W = 16
) (
    input  logic                             full_size,
    input  logic [$clog2(DATA_W/8)-1:0]      lane_sel,
    input  logic [DATA_W-1:0]                wdata_in,
    input  logic [DATA_W-1:0]                rdata_in,
    output logic [DATA_W/8-1:0]              lane_en,
    output logic [DATA_W-1:0]                wdata_out,
    output logic [DATA_W-1:0]                rdata_out
);

    localparam int unsigned LANES = DATA_W / 8;

    logic [LANES-1:0][7:0] rd_lanes;
    logic [7:0]            rd_pick;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Enable and write data for one lane.
            always_comb begin
                lane_en[g]             = full_size || (lane_sel == g);
                wdata_out[g*8 +: 8]    = full_size ? wdata_in[g*8 +: 8] : wdata_in[7:0];
                rd_lanes[g]            = rdata_in[g*8 +: 8];
            end
        end
    endgenerate

    // Select and zero-extend the read lane for byte accesses.
    always_comb begin
        rd_pick   = rd_lanes[lane_sel];
        rdata_out = full_size ? rdata_in : {{(DATA_W-8){1'b0}}, rd_pick};
    end

endmodule

// File: rtl/pab_seq.sv
// Access sequencer. Walks one access through preparation, bus-edge wait,
// bus stage, peripheral-edge wait, peripheral stage and read return, and
// pulses done in the first cycle after the last stage. Assumes the ratios
// are stable while not idle.
module pab_seq
    import pab_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            is_write,
    input  logic [BR_W-1:0] bus_ratio,
    input  logic [PR_W-1:0] prf_ratio,
    input  logic            bus_ce,
    input  logic            prf_ce,
    output logic            idle,
    output logic            prf_active,
    output logic            capture_rd,
    output logic            done
);

    seq_state_t        state;
    logic [WAIT_W-1:0] wcnt;
    logic [WAIT_W-1:0] stage_len;
    logic              last_wait;

    assign stage_len  = WAIT_W'(PRF_STAGE_LEN) * WAIT_W'(bus_ratio) * WAIT_W'(prf_ratio);
    assign last_wait  = (wcnt == '0);
    assign idle       = (state == ST_IDLE);
    assign prf_active = (state == ST_PRFS) || ((state == ST_PRFW) && prf_ce);
    assign capture_rd = (state == ST_PRFS) && last_wait && !is_write;

    // Advance the access through its stages and emit the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_PREP;
                        wcnt  <= WAIT_W'(PREP_CYCLES - 1);
                    end
                end
                ST_PREP: begin
                    if (last_wait) state <= ST_BUSW;
                    else           wcnt  <= wcnt - 1'b1;
                end
                ST_BUSW: begin
                    if (bus_ce) begin
                        if (bus_ratio == BR_W'(1)) begin
                            state <= ST_PRFW;
                        end else begin
                            state <= ST_BUSS;
                            wcnt  <= WAIT_W'(bus_ratio) - WAIT_W'(2);
                        end
                    end
                end
                ST_BUSS: begin
                    if (last_wait) state <= ST_PRFW;
                    else           wcnt  <= wcnt - 1'b1;
                end
                ST_PRFW: begin
                    if (prf_ce) begin
                        state <= ST_PRFS;
                        wcnt  <= stage_len - WAIT_W'(2);
                    end
                end
                ST_PRFS: begin
                    if (last_wait) begin
                        if (is_write) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_RET;
                            wcnt  <= WAIT_W'(RET_CYCLES - 1);
                        end
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_RET: begin
                    if (last_wait) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/periph_access_bridge.sv
// Peripheral register access bridge with ratio-related clock timing.
// Captures one request at a time, drives the peripheral port during the
// peripheral stage and returns read data with a done pulse. Assumes a
// 16-bit-class peripheral path addressed in DATA_W/8-byte words.
module periph_access_bridge
    import pab_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CODE_W-1:0]             cfg_bus_ratio,
    input  logic [CODE_W-1:0]             cfg_prf_ratio,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic                          req_size,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          busy,
    output logic                          done,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          bus_ce,
    output logic                          prf_ce,
    output logic                          prf_sel,
    output logic                          prf_write,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] prf_addr,
    output logic [DATA_W-1:0]             prf_wdata,
    output logic [DATA_W/8-1:0]           prf_lane_en,
    input  logic [DATA_W-1:0]             prf_rdata
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned LSB_W = $clog2(LANES);

    logic              idle;
    logic              accept;
    logic              restart;
    logic              capture_rd;
    logic [BR_W-1:0]   bus_ratio_q;
    logic [PR_W-1:0]   prf_ratio_q;
    logic              wr_q;
    logic              size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_steered;

    assign accept = idle && req_valid;
    assign busy   = !idle;

    pab_ratio_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .bus_code  (cfg_bus_ratio),
        .prf_code  (cfg_prf_ratio),
        .bus_ratio (bus_ratio_q),
        .prf_ratio (prf_ratio_q),
        .restart   (restart)
    );

    pab_strobe_gen u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .bus_ratio (bus_ratio_q),
        .prf_ratio (prf_ratio_q),
        .bus_ce    (bus_ce),
        .prf_ce    (prf_ce)
    );

    pab_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .is_write   (wr_q),
        .bus_ratio  (bus_ratio_q),
        .prf_ratio  (prf_ratio_q),
        .bus_ce     (bus_ce),
        .prf_ce     (prf_ce),
        .idle       (idle),
        .prf_active (prf_sel),
        .capture_rd (capture_rd),
        .done       (done)
    );

    pab_lane #(.DATA_W(DATA_W)) u_lane (
        .full_size (size_q),
        .lane_sel  (addr_q[LSB_W-1:0]),
        .wdata_in  (wdata_q),
        .rdata_in  (prf_rdata),
        .lane_en   (prf_lane_en),
        .wdata_out (prf_wdata),
        .rdata_out (rd_steered)
    );

    // Capture the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            size_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            size_q  <= req_size;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Latch steered read data in the last peripheral-stage cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture_rd) begin
            rd_data <= rd_steered;
        end
    end

    assign prf_write = wr_q;
    assign prf_addr  = addr_q[ADDR_W-1:LSB_W];

endmodule

// File: rtl/pab_checker.sv
// Protocol checker for the peripheral access bridge, attached by bind.
// Observes ports and the applied ratio registers.
module pab_checker
    import pab_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            req_valid,
    input logic            bus_ce,
    input logic            prf_ce,
    input logic            prf_sel,
    input logic [BR_W-1:0] bus_ratio,
    input logic [PR_W-1:0] prf_ratio
);

    assert_prf_in_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prf_ce |-> bus_ce);

    assert_unit_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ratio == BR_W'(1)) |-> bus_ce);

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(bus_ratio) && $stable(prf_ratio)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_sel_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prf_sel |-> busy);

endmodule

bind periph_access_bridge pab_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .bus_ce    (bus_ce),
    .prf_ce    (prf_ce),
    .prf_sel   (prf_sel),
    .bus_ratio (bus_ratio_q),
    .prf_ratio (prf_ratio_q)
);

// File: tb/periph_access_bridge_bench.sv
`timescale 1ns/1ps
module periph_access_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_bus_ratio = 3'd0;
    logic [2:0]  cfg_prf_ratio = 3'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_size = 1'b1;
    logic [11:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, bus_ce, prf_ce, prf_sel, prf_write;
    logic [15:0] rd_data, prf_wdata, prf_rdata;
    logic [10:0] prf_addr;
    logic [1:0]  prf_lane_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] per_mem [0:63];
    logic [15:0] exp_mem [0:63];

    localparam logic [11:0] POKE_ADDR = 12'h07E;

    // Vector: {bus code, peripheral code, idle gap before the access}
    localparam logic [9:0] VEC [0:21] = '{
        {3'd0, 3'd0, 4'd0}, {3'd1, 3'd0, 4'd1}, {3'd2, 3'd0, 4'd2}, {3'd3, 3'd0, 4'd3},
        {3'd4, 3'd0, 4'd5}, {3'd0, 3'd1, 4'd1}, {3'd1, 3'd1, 4'd0}, {3'd2, 3'd1, 4'd4},
        {3'd3, 3'd1, 4'd2}, {3'd4, 3'd1, 4'd7}, {3'd0, 3'd2, 4'd2}, {3'd1, 3'd2, 4'd3},
        {3'd2, 3'd2, 4'd1}, {3'd3, 3'd2, 4'd6}, {3'd4, 3'd2, 4'd0}, {3'd0, 3'd3, 4'd3},
        {3'd1, 3'd3, 4'd5}, {3'd2, 3'd3, 4'd0}, {3'd3, 3'd3, 4'd9}, {3'd4, 3'd3, 4'd11},
        {3'd6, 3'd5, 4'd2}, {3'd5, 3'd7, 4'd4}
    };

    periph_access_bridge u_periph_access_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_bus_ratio(cfg_bus_ratio), .cfg_prf_ratio(cfg_prf_ratio),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data), .bus_ce(bus_ce),
        .prf_ce(prf_ce), .prf_sel(prf_sel), .prf_write(prf_write), .prf_addr(prf_addr),
        .prf_wdata(prf_wdata), .prf_lane_en(prf_lane_en), .prf_rdata(prf_rdata)
    );

    always #2 clk = ~clk;

    // Peripheral register model: lane-masked write on a peripheral edge.
    assign prf_rdata = per_mem[prf_addr[5:0]];
    always @(posedge clk) begin
        if (prf_sel && prf_write && prf_ce) begin
            if (prf_lane_en[0]) per_mem[prf_addr[5:0]][7:0]  <= prf_wdata[7:0];
            if (prf_lane_en[1]) per_mem[prf_addr[5:0]][15:8] <= prf_wdata[15:8];
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int dec_b(input logic [2:0] c);
        case (c) 3'd1: return 2; 3'd2: return 3; 3'd3: return 4; 3'd4: return 8; default: return 1; endcase
    endfunction

    function automatic int dec_p(input logic [2:0] c);
        case (c) 3'd1: return 2; 3'd2: return 3; 3'd3: return 4; default: return 1; endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access, started at a negedge; checks timing, port behaviour and data.
    task automatic do_access(input logic wr, input logic sz, input logic [11:0] a,
                             input logic [15:0] wd, input bit poke);
        int   b = dec_b(cfg_bus_ratio);
        int   p = dec_p(cfg_prf_ratio);
        logic bce [0:511];
        logic pce [0:511];
        int   len = 0, done_at = -1, done_cnt = 0, sel_cnt = 0, busy_bad = 0, port_bad = 0;
        int   strobe_bad = 0, jb = -1, jp = -1, exp_l;
        logic [15:0] rd_got = '0, exp_rd, w;
        logic [2:0]  keep_b = cfg_bus_ratio;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        for (int j = 0; j < 512; j++) begin
            @(negedge clk);
            bce[j] = bus_ce; pce[j] = prf_ce; len = j + 1;
            if (done) begin
                done_cnt++;
                if (done_at < 0) begin done_at = j; rd_got = rd_data; end
            end
            if ((done_at < 0) != busy) busy_bad++;
            if (prf_sel) begin
                sel_cnt++;
                if (prf_addr != a[11:1] || prf_write != wr) port_bad++;
            end
            if (j == 0) req_valid = 1'b0;
            if (poke && j == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_size = 1'b1;
                req_addr = POKE_ADDR; req_wdata = 16'hDEAD;
                cfg_bus_ratio = (keep_b == 3'd4) ? 3'd0 : 3'd4;
            end
            if (poke && j == 3) begin req_valid = 1'b0; cfg_bus_ratio = keep_b; end
            if (done_at >= 0 && j >= done_at + 3) break;
        end
        for (int j = 0; j < len; j++) begin
            if (pce[j] && !bce[j]) strobe_bad++;
            if (bce[j]) begin
                for (int q = 1; q < b && j + q < len; q++) if (bce[j+q]) strobe_bad++;
                if (j + b < len && !bce[j+b]) strobe_bad++;
            end
            if (pce[j]) begin
                for (int q = 1; q < b*p && j + q < len; q++) if (pce[j+q]) strobe_bad++;
                if (j + b*p < len && !pce[j+b*p]) strobe_bad++;
            end
            if (jb < 0 && j >= 3 && bce[j]) jb = j;
        end
        for (int j = jb + b; jb >= 0 && j < len; j++) if (jp < 0 && pce[j]) jp = j;
        exp_l = (jp < 0) ? -1 : jp + 2*b*p + (wr ? 0 : 2);
        chk(strobe_bad == 0, "R3", "strobe spacing faults", strobe_bad, 0);
        chk(done_at == exp_l && exp_l > 0, wr ? "R5" : "R6", "done cycle", done_at, exp_l);
        chk(done_cnt == 1, poke ? "R7" : "R8", "done pulses", done_cnt, 1);
        chk(busy_bad == 0, poke ? "R7" : "R8", "busy window faults", busy_bad, 0);
        chk(sel_cnt == 2*b*p, poke ? "R4" : "R9", "prf_sel cycles", sel_cnt, 2*b*p);
        chk(port_bad == 0, "R9", "address/write faults", port_bad, 0);
        w = exp_mem[a[6:1]];
        if (wr) begin
            if (sz) w = wd;
            else if (a[0]) w[15:8] = wd[7:0];
            else w[7:0] = wd[7:0];
            exp_mem[a[6:1]] = w;
        end else begin
            exp_rd = sz ? w : {8'h00, (a[0] ? w[15:8] : w[7:0])};
            chk(rd_got == exp_rd, "R11", "read data", rd_got, exp_rd);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            per_mem[i] = 16'(i * 16'h0203 + 16'h0011);
            exp_mem[i] = 16'(i * 16'h0203 + 16'h0011);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !prf_sel, "R1", "busy/done/sel", {busy, done, prf_sel}, 0);
        chk(rd_data == 16'h0, "R1", "rd_data", rd_data, 0);
        chk(bus_ce && prf_ce, "R1", "strobes", {bus_ce, prf_ce}, 3);

        // R2/R3: ratio code 4 gives 8-cycle bus strobe, restarted on apply
        cfg_bus_ratio = 3'd4; cfg_prf_ratio = 3'd1;
        begin
            int hits = 0, phits = 0;
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                if (j == 0) chk(bus_ce && prf_ce, "R3", "restart phase", {bus_ce, prf_ce}, 3);
                hits += bus_ce; phits += prf_ce;
                if (j == 8) chk(bus_ce && !prf_ce, "R2", "bus strobe at 8", {bus_ce, prf_ce}, 2);
            end
            chk(hits == 2 && phits == 1, "R2", "strobe counts over 16", hits*16 + phits, 33);
        end
        // R2: unsupported codes fall back to 1:1
        cfg_bus_ratio = 3'd6; cfg_prf_ratio = 3'd7;
        begin
            int hits = 0;
            @(negedge clk);
            for (int j = 0; j < 10; j++) begin @(negedge clk); hits += (bus_ce && prf_ce); end
            chk(hits == 10, "R2", "unsupported code strobes", hits, 10);
        end

        // Table walk: write then read back at each ratio pair and phase
        for (int i = 0; i < 22; i++) begin
            cfg_bus_ratio = VEC[i][9:7];
            cfg_prf_ratio = VEC[i][6:4];
            @(negedge clk);
            repeat (int'(VEC[i][3:0])) @(negedge clk);
            do_access(1'b1, 1'b1, 12'(i * 2), 16'(16'h3C00 + i * 16'h0111), 1'b0);
            do_access(1'b0, 1'b1, 12'(i * 2), 16'h0000, 1'b0);
        end

        // R10/R11: byte lanes
        cfg_bus_ratio = 3'd1; cfg_prf_ratio = 3'd1;
        @(negedge clk);
        req_valid = 1'b0;
        do_access(1'b1, 1'b0, 12'h061, 16'h77A5, 1'b0);
        do_access(1'b1, 1'b0, 12'h062, 16'h883C, 1'b0);
        do_access(1'b0, 1'b0, 12'h061, 16'h0000, 1'b0);
        do_access(1'b0, 1'b0, 12'h062, 16'h0000, 1'b0);
        do_access(1'b0, 1'b1, 12'h060, 16'h0000, 1'b0);
        // R10: lane enable and steering seen at the port
        req_valid = 1'b1; req_write = 1'b1; req_size = 1'b0; req_addr = 12'h065; req_wdata = 16'h00C3;
        begin
            bit seen = 1'b0;
            for (int j = 0; j < 200 && !done; j++) begin
                @(negedge clk);
                req_valid = 1'b0;
                if (prf_sel && !seen) begin
                    seen = 1'b1;
                    chk(prf_lane_en == 2'b10 && prf_wdata[15:8] == 8'hC3, "R10", "odd byte lane",
                        {prf_lane_en, prf_wdata}, {2'b10, 16'hC3C3});
                end
            end
            chk(seen, "R10", "peripheral stage seen", seen, 1);
        end
        exp_mem[6'h32][15:8] = 8'hC3;
        @(negedge clk);

        // R7/R4: request and ratio change during an access are ignored
        cfg_bus_ratio = 3'd2; cfg_prf_ratio = 3'd2;
        @(negedge clk);
        do_access(1'b0, 1'b1, 12'h010, 16'h0000, 1'b1);
        do_access(1'b1, 1'b1, 12'h012, 16'h5A5A, 1'b1);
        do_access(1'b0, 1'b1, POKE_ADDR, 16'h0000, 1'b0);
        chk(per_mem[POKE_ADDR[6:1]] == exp_mem[POKE_ADDR[6:1]], "R7", "poked register",
            per_mem[POKE_ADDR[6:1]], exp_mem[POKE_ADDR[6:1]]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule